// File: doc/BRIEF.md
# Debug-Mode CSR and Instruction Guard

This block is the core-side support unit for external debug. It holds the debug control and status register (called `dcsr` in the notes) and the debug program counter (`dpc`). It also maps an externally held data word into the CSR space as a debug-only register at address 0x7b2, and screens incoming instructions while the hart is halted. The debug module sends it instructions to run. Any instruction whose result depends on the program counter is flagged, because the instruction stream in debug mode comes from the debug module and carries no meaningful PC. The core uses that flag to raise an exception, which stops program-buffer execution.

The core's CSR stage presents an address, a write flag and write data, and takes back read data and an illegal-access flag in the same cycle. Accesses to the data word do not store anything locally. Reads pass through from the external register. Writes appear as a one-cycle strobe with data toward that register. On debug entry the core pulses an entry input with a cause code and the PC to resume at. The block records both, and they are visible on the next cycle.

Several `dcsr` fields are fixed: single-step interrupts off, counters and timer stopped, machine privilege only. The block has no scratch registers and no return-from-debug instruction, because the debug module resumes the hart through its own request line.

Top module: `dbg_csr_guard`

## Requirements
- R1: While `dbg_mode`=1, a valid instruction whose bits [6:0] equal 1100011 (conditional branch), 1101111 (jal), 1100111 (jalr) or 0010111 (auipc) sets `instr_illegal`. No other opcode sets it, and with `dbg_mode`=0 these opcodes do not set it either.
- R2: The return-from-debug encoding 32'h7b200073 sets `instr_illegal` in either mode whenever `instr_valid`=1.
- R3: Any CSR access in the debug range 0x7b0..0x7bf with `dbg_mode`=0 sets `csr_illegal`, and the read data is 0.
- R4: With `dbg_mode`=1, only 0x7b0 (`dcsr`), 0x7b1 (`dpc`) and 0x7b2 (data word) are legal in the debug range; 0x7b3..0x7bf set `csr_illegal`. Addresses outside the range never set `csr_illegal` and read as 0.
- R5: A legal access to 0x7b2 returns `data0_rdata`. A legal write to it drives `data0_wen`=1 with `data0_wdata`=`csr_wdata` in that same cycle. `data0_wen` stays 0 for any illegal access.
- R6: `dcsr` fixed fields read constant and ignore writes: [31:28]=4, [11] (step interrupts)=0, [10] (stop counters)=1, [9] (stop timer)=1, [4] (privilege-modify enable)=0, [1:0] (privilege)=3, all other unlisted bits 0. After reset `dcsr` reads 32'h40000603.
- R7: `dcsr` bit 15 (ebreak enters debug from machine mode) and bit 2 (single step) are writable. The cause field [8:6] ignores CSR writes.
- R8: A cycle with `dbg_entry`=1 loads `dcsr`[8:6] with `dbg_entry_cause` (1 ebreak, 2 trigger, 3 halt request, 4 step), visible from the next cycle.
- R9: A cycle with `dbg_entry`=1 loads `dpc` with `dbg_entry_pc`, with its low bits cleared (two bits when IALIGN=32, one when IALIGN=16), visible from the next cycle. Entry takes precedence over a CSR write in the same cycle.
- R10: A legal write to `dpc` stores `csr_wdata` with the same low-bit clearing as R9.
- R11: An access that sets `csr_illegal` changes neither `dcsr` nor `dpc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dbg_mode | input | 1 | Hart is halted in debug mode |
| instr_valid | input | 1 | `instr` holds an instruction about to execute |
| instr | input | 32 | Instruction word |
| instr_illegal | output | 1 | Instruction is not allowed in the current mode |
| csr_en | input | 1 | A CSR access is presented this cycle |
| csr_wen | input | 1 | The access writes |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | XLEN | CSR write data |
| csr_rdata | output | XLEN | CSR read data for a debug-range address |
| csr_illegal | output | 1 | Access must raise an illegal-instruction exception |
| data0_rdata | input | XLEN | Current value of the external data word |
| data0_wen | output | 1 | Write strobe toward the external data word |
| data0_wdata | output | XLEN | Write data toward the external data word |
| dbg_entry | input | 1 | Hart enters debug mode this cycle |
| dbg_entry_cause | input | 3 | Reason for entry |
| dbg_entry_pc | input | XLEN | PC to resume at |

## Verification
The bench builds the block with XLEN=32 and IALIGN=32, so the four-byte alignment mask on `dpc` is in use. That setting makes a sweep over all 128 seven-bit major opcodes in both modes cheap enough to be exhaustive. It also covers all sixteen addresses of the debug CSR window in both modes, so every legal/illegal combination of mode and address is compared against an arithmetic model. Entry causes 1 to 4 are each loaded and read back. The bench also tries a CSR write and an entry in the same cycle to confirm that entry wins, and writes to the fixed `dcsr` fields to confirm they do not change.

// File: rtl/dbg_csr_pkg.sv
`timescale 1ns/1ps
package dbg_csr_pkg;

   localparam logic [11:0] DBG_RANGE_BASE = 12'h7b0;
   localparam logic [11:0] DBG_DCSR_ADDR  = 12'h7b0;
   localparam logic [11:0] DBG_DPC_ADDR   = 12'h7b1;
   localparam logic [11:0] DBG_DATA_ADDR  = 12'h7b2;

   localparam logic [6:0] OPC_BRANCH = 7'b1100011;
   localparam logic [6:0] OPC_JAL    = 7'b1101111;
   localparam logic [6:0] OPC_JALR   = 7'b1100111;
   localparam logic [6:0] OPC_AUIPC  = 7'b0010111;

   localparam logic [31:0] RET_FROM_DEBUG = 32'h7b200073;

   typedef enum logic [2:0] {
      CAUSE_NONE    = 3'd0,
      CAUSE_EBREAK  = 3'd1,
      CAUSE_TRIGGER = 3'd2,
      CAUSE_HALTREQ = 3'd3,
      CAUSE_STEP    = 3'd4
   } halt_cause_e;

   typedef struct packed {
      logic        brk_m;
      logic        step;
      halt_cause_e cause;
   } dctl_state_t;

   function automatic logic [31:0] pack_dcsr(input dctl_state_t s, input logic [3:0] ver);
      logic [31:0] v;
      v        = '0;
      v[31:28] = ver;
      v[15]    = s.brk_m;
      v[11]    = 1'b0;
      v[10]    = 1'b1;
      v[9]     = 1'b1;
      v[8:6]   = s.cause;
      v[4]     = 1'b0;
      v[2]     = s.step;
      v[1:0]   = 2'b11;
      return v;
   endfunction

endpackage

// File: rtl/dbg_instr_guard.sv
`timescale 1ns/1ps
module dbg_instr_guard
   import dbg_csr_pkg::*;
#(
   parameter int ILEN = 32
) (
   input  logic            dbg_mode,
   input  logic            instr_valid,
   input  logic [ILEN-1:0] instr,
   output logic            instr_illegal
);

   localparam int OPC_W = 7;

   if (ILEN != 32) begin : g_bad_ilen
      $error("dbg_instr_guard: ILEN must be 32");
   end

   logic [OPC_W-1:0] opc;
   logic             pc_observer;
   logic             is_ret;

   assign opc = instr[OPC_W-1:0];

   always_comb begin
      unique case (opc)
         OPC_BRANCH, OPC_JAL, OPC_JALR, OPC_AUIPC: pc_observer = 1'b1;
         default:                                  pc_observer = 1'b0;
      endcase
   end

   assign is_ret        = (instr == RET_FROM_DEBUG);
   assign instr_illegal = instr_valid & ((dbg_mode & pc_observer) | is_ret);

endmodule

// File: rtl/dbg_csr_decode.sv
`timescale 1ns/1ps
module dbg_csr_decode
   import dbg_csr_pkg::*;
#(
   parameter int XLEN   = 32,
   parameter int ADDR_W = 12
) (
   input  logic              dbg_mode,
   input  logic              csr_en,
   input  logic              csr_wen,
   input  logic [ADDR_W-1:0] csr_addr,
   input  logic [XLEN-1:0]   dcsr_val,
   input  logic [XLEN-1:0]   dpc_val,
   input  logic [XLEN-1:0]   data0_val,
   output logic              dcsr_we,
   output logic              dpc_we,
   output logic              data0_we,
   output logic              illegal,
   output logic [XLEN-1:0]   rdata
);

   localparam int WIN_BITS = 4;

   if (ADDR_W != 12) begin : g_bad_addr
      $error("dbg_csr_decode: ADDR_W must be 12");
   end

   logic in_win, hit_dcsr, hit_dpc, hit_data, known, legal;

   assign in_win   = (csr_addr[ADDR_W-1:WIN_BITS] == DBG_RANGE_BASE[ADDR_W-1:WIN_BITS]);
   assign hit_dcsr = (csr_addr == DBG_DCSR_ADDR);
   assign hit_dpc  = (csr_addr == DBG_DPC_ADDR);
   assign hit_data = (csr_addr == DBG_DATA_ADDR);
   assign known    = hit_dcsr | hit_dpc | hit_data;

   assign illegal  = csr_en & in_win & (~dbg_mode | ~known);
   assign legal    = csr_en & in_win & dbg_mode & known;

   assign dcsr_we  = legal & csr_wen & hit_dcsr;
   assign dpc_we   = legal & csr_wen & hit_dpc;
   assign data0_we = legal & csr_wen & hit_data;

   always_comb begin
      rdata = '0;
      if (legal) begin
         if (hit_dcsr)      rdata = dcsr_val;
         else if (hit_dpc)  rdata = dpc_val;
         else               rdata = data0_val;
      end
   end

endmodule

// File: rtl/dbg_dcsr_regs.sv
`timescale 1ns/1ps
module dbg_dcsr_regs
   import dbg_csr_pkg::*;
#(
   parameter int XLEN      = 32,
   parameter int IALIGN    = 32,
   parameter int XDEBUGVER = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            dcsr_we,
   input  logic            wr_brk_m,
   input  logic            wr_step,
   input  logic            dpc_we,
   input  logic [XLEN-1:0] dpc_wdata,
   input  logic            entry,
   input  logic [2:0]      entry_cause,
   input  logic [XLEN-1:0] entry_pc,
   output logic [XLEN-1:0] dcsr_val,
   output logic [XLEN-1:0] dpc_val
);

   localparam logic [3:0] VER = 4'(XDEBUGVER);

   if (XLEN != 32 && XLEN != 64) begin : g_bad_xlen
      $error("dbg_dcsr_regs: XLEN must be 32 or 64");
   end
   if (XDEBUGVER < 0 || XDEBUGVER > 15) begin : g_bad_ver
      $error("dbg_dcsr_regs: XDEBUGVER must fit in four bits");
   end

   logic [XLEN-1:0] align_mask;

   if (IALIGN == 16) begin : g_align16
      assign align_mask = {{(XLEN-1){1'b1}}, 1'b0};
   end else if (IALIGN == 32) begin : g_align32
      assign align_mask = {{(XLEN-2){1'b1}}, 2'b00};
   end else begin : g_bad_ialign
      $error("dbg_dcsr_regs: IALIGN must be 16 or 32");
      assign align_mask = '0;
   end

   dctl_state_t     st_q;
   logic [XLEN-1:0] dpc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= '{brk_m: 1'b0, step: 1'b0, cause: CAUSE_NONE};
      end else if (entry) begin
         st_q.cause <= halt_cause_e'(entry_cause);
      end else if (dcsr_we) begin
         st_q.brk_m <= wr_brk_m;
         st_q.step  <= wr_step;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      dpc_q <= '0;
      else if (entry)  dpc_q <= entry_pc & align_mask;
      else if (dpc_we) dpc_q <= dpc_wdata & align_mask;
   end

   assign dcsr_val = XLEN'(pack_dcsr(st_q, VER));
   assign dpc_val  = dpc_q;

   // R8
   cause_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      entry |=> (dcsr_val[8:6] == $past(entry_cause)));

   // R9
   dpc_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      entry |=> (dpc_val == ($past(entry_pc) & align_mask)));

   // R7
   cause_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dcsr_we && !entry) |=> (dcsr_val[8:6] == $past(dcsr_val[8:6])));

   // R11
   dpc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!entry && !dpc_we) |=> $stable(dpc_val));

endmodule

// File: rtl/dbg_csr_guard.sv
`timescale 1ns/1ps
module dbg_csr_guard
   import dbg_csr_pkg::*;
#(
   parameter int XLEN      = 32,
   parameter int IALIGN    = 32,
   parameter int XDEBUGVER = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            dbg_mode,
   input  logic            instr_valid,
   input  logic [31:0]     instr,
   output logic            instr_illegal,
   input  logic            csr_en,
   input  logic            csr_wen,
   input  logic [11:0]     csr_addr,
   input  logic [XLEN-1:0] csr_wdata,
   output logic [XLEN-1:0] csr_rdata,
   output logic            csr_illegal,
   input  logic [XLEN-1:0] data0_rdata,
   output logic            data0_wen,
   output logic [XLEN-1:0] data0_wdata,
   input  logic            dbg_entry,
   input  logic [2:0]      dbg_entry_cause,
   input  logic [XLEN-1:0] dbg_entry_pc
);

   logic            dcsr_we, dpc_we;
   logic [XLEN-1:0] dcsr_val, dpc_val;

   dbg_instr_guard #(.ILEN(32)) guard_i (
      .dbg_mode      (dbg_mode),
      .instr_valid   (instr_valid),
      .instr         (instr),
      .instr_illegal (instr_illegal)
   );

   dbg_csr_decode #(.XLEN(XLEN), .ADDR_W(12)) decode_i (
      .dbg_mode  (dbg_mode),
      .csr_en    (csr_en),
      .csr_wen   (csr_wen),
      .csr_addr  (csr_addr),
      .dcsr_val  (dcsr_val),
      .dpc_val   (dpc_val),
      .data0_val (data0_rdata),
      .dcsr_we   (dcsr_we),
      .dpc_we    (dpc_we),
      .data0_we  (data0_wen),
      .illegal   (csr_illegal),
      .rdata     (csr_rdata)
   );

   dbg_dcsr_regs #(.XLEN(XLEN), .IALIGN(IALIGN), .XDEBUGVER(XDEBUGVER)) regs_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .dcsr_we     (dcsr_we),
      .wr_brk_m    (csr_wdata[15]),
      .wr_step     (csr_wdata[2]),
      .dpc_we      (dpc_we),
      .dpc_wdata   (csr_wdata),
      .entry       (dbg_entry),
      .entry_cause (dbg_entry_cause),
      .entry_pc    (dbg_entry_pc),
      .dcsr_val    (dcsr_val),
      .dpc_val     (dpc_val)
   );

   assign data0_wdata = csr_wdata;

   // R1
   pc_guard_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_illegal && !dbg_mode) |-> (instr == RET_FROM_DEBUG));

   // R5
   data_strobe_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      data0_wen |-> (!csr_illegal && dbg_mode && csr_en));

   // R3
   mmode_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      csr_illegal |-> (csr_rdata == '0 && !data0_wen));

   // R6
   dcsr_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_en && dbg_mode && csr_addr == DBG_DCSR_ADDR) |->
         (csr_rdata[31:28] == 4'(XDEBUGVER) && csr_rdata[11:9] == 3'b011 &&
          csr_rdata[4] == 1'b0 && csr_rdata[1:0] == 2'b11));

endmodule

// File: tb/dbg_csr_guard_tb.sv
`timescale 1ns/1ps
module dbg_csr_guard_tb_top;

   localparam int XLEN = 32;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            dbg_mode = 1'b0;
   logic            instr_valid = 1'b0;
   logic [31:0]     instr = '0;
   logic            instr_illegal;
   logic            csr_en = 1'b0;
   logic            csr_wen = 1'b0;
   logic [11:0]     csr_addr = '0;
   logic [XLEN-1:0] csr_wdata = '0;
   logic [XLEN-1:0] csr_rdata;
   logic            csr_illegal;
   logic [XLEN-1:0] data0_rdata = 32'hA5C3_0F96;
   logic            data0_wen;
   logic [XLEN-1:0] data0_wdata;
   logic            dbg_entry = 1'b0;
   logic [2:0]      dbg_entry_cause = '0;
   logic [XLEN-1:0] dbg_entry_pc = '0;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   dbg_csr_guard #(.XLEN(XLEN), .IALIGN(32), .XDEBUGVER(4)) dut_i (
      .clk(clk), .rst_n(rst_n), .dbg_mode(dbg_mode),
      .instr_valid(instr_valid), .instr(instr), .instr_illegal(instr_illegal),
      .csr_en(csr_en), .csr_wen(csr_wen), .csr_addr(csr_addr),
      .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .csr_illegal(csr_illegal),
      .data0_rdata(data0_rdata), .data0_wen(data0_wen), .data0_wdata(data0_wdata),
      .dbg_entry(dbg_entry), .dbg_entry_cause(dbg_entry_cause),
      .dbg_entry_pc(dbg_entry_pc)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // one CSR access: presented after a falling edge, sampled 2 ns later, committed at the next rising edge
   task automatic csr_go(input logic mode, input logic [11:0] a, input logic w, input logic [31:0] d,
                         output logic [31:0] rd, output logic ill, output logic dwe);
      @(negedge clk);
      dbg_mode = mode; csr_en = 1'b1; csr_addr = a; csr_wen = w; csr_wdata = d;
      #2;
      rd = csr_rdata; ill = csr_illegal; dwe = data0_wen;
      @(negedge clk);
      csr_en = 1'b0; csr_wen = 1'b0;
   endtask

   function automatic logic [31:0] dcsr_exp(input logic bm, input logic st, input logic [2:0] c);
      return 32'h4000_0603 | (32'(bm) << 15) | (32'(st) << 2) | (32'(c) << 6);
   endfunction

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin : stim
      logic [31:0] rd;
      logic ill, dwe, e_ill;
      logic [6:0] op;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R6 reset value
      csr_go(1'b1, 12'h7b0, 1'b0, '0, rd, ill, dwe);
      check("R6 reset dcsr", rd, 32'h4000_0603);
      csr_go(1'b1, 12'h7b1, 1'b0, '0, rd, ill, dwe);
      check("R9 reset dpc", rd, 32'h0);

      // R1 exhaustive opcode sweep in both modes
      for (int m = 0; m < 2; m++) begin
         for (int o = 0; o < 128; o++) begin
            @(negedge clk);
            op = 7'(o);
            dbg_mode = m[0]; instr_valid = 1'b1; instr = {25'h1555555, op};
            #2;
            e_ill = m[0] && (op == 7'b1100011 || op == 7'b1101111 ||
                             op == 7'b1100111 || op == 7'b0010111);
            check("R1 opcode guard", {31'd0, instr_illegal}, {31'd0, e_ill});
         end
      end
      @(negedge clk);
      instr_valid = 1'b0; dbg_mode = 1'b1; instr = {25'h0, 7'b1101111};
      #2 check("R1 no flag without valid", {31'd0, instr_illegal}, 32'd0);

      // R2 return-from-debug in both modes
      for (int m = 0; m < 2; m++) begin
         @(negedge clk);
         dbg_mode = m[0]; instr_valid = 1'b1; instr = 32'h7b200073;
         #2 check("R2 ret illegal", {31'd0, instr_illegal}, 32'd1);
      end
      @(negedge clk);
      instr_valid = 1'b0;

      // R3 / R4 sweep of the debug window in both modes (reads)
      for (int m = 0; m < 2; m++) begin
         for (int a = 0; a < 16; a++) begin
            csr_go(m[0], 12'h7b0 + 12'(a), 1'b0, '0, rd, ill, dwe);
            e_ill = !m[0] || a > 2;
            if (m == 0) check("R3 window illegal outside debug", {31'd0, ill}, {31'd0, e_ill});
            else        check("R4 window legality in debug", {31'd0, ill}, {31'd0, e_ill});
            if (e_ill) check("R3 illegal read zero", rd, 32'd0);
         end
      end
      csr_go(1'b0, 12'h300, 1'b0, '0, rd, ill, dwe);
      check("R4 outside range not flagged", {31'd0, ill}, 32'd0);
      check("R4 outside range reads zero", rd, 32'd0);
      csr_go(1'b1, 12'h7a0, 1'b1, 32'hFFFF_FFFF, rd, ill, dwe);
      check("R4 neighbour range not flagged", {31'd0, ill}, 32'd0);

      // R5 data word
      csr_go(1'b1, 12'h7b2, 1'b0, '0, rd, ill, dwe);
      check("R5 data read", rd, 32'hA5C3_0F96);
      check("R5 no strobe on read", {31'd0, dwe}, 32'd0);
      @(negedge clk);
      dbg_mode = 1'b1; csr_en = 1'b1; csr_wen = 1'b1; csr_addr = 12'h7b2; csr_wdata = 32'h1357_9BDF;
      #2;
      check("R5 data strobe", {31'd0, data0_wen}, 32'd1);
      check("R5 data wdata", data0_wdata, 32'h1357_9BDF);
      @(negedge clk);
      csr_en = 1'b0; csr_wen = 1'b0;
      csr_go(1'b0, 12'h7b2, 1'b1, 32'h1, rd, ill, dwe);
      check("R5 no strobe in machine mode", {31'd0, dwe}, 32'd0);
      csr_go(1'b1, 12'h7b5, 1'b1, 32'h1, rd, ill, dwe);
      check("R5 no strobe on unimplemented", {31'd0, dwe}, 32'd0);

      // R6 / R7 writes
      csr_go(1'b1, 12'h7b0, 1'b1, 32'hFFFF_FFFF, rd, ill, dwe);
      csr_go(1'b1, 12'h7b0, 1'b0, '0, rd, ill, dwe);
      check("R7 all-ones write", rd, dcsr_exp(1'b1, 1'b1, 3'd0));
      csr_go(1'b1, 12'h7b0, 1'b1, 32'h0000_8000, rd, ill, dwe);
      csr_go(1'b1, 12'h7b0, 1'b0, '0, rd, ill, dwe);
      check("R7 ebreak bit only", rd, dcsr_exp(1'b1, 1'b0, 3'd0));
      csr_go(1'b1, 12'h7b0, 1'b1, 32'h0000_0000, rd, ill, dwe);
      csr_go(1'b1, 12'h7b0, 1'b0, '0, rd, ill, dwe);
      check("R6 all-zero write keeps fixed", rd, dcsr_exp(1'b0, 1'b0, 3'd0));

      // R11 illegal writes leave state
      csr_go(1'b0, 12'h7b0, 1'b1, 32'hFFFF_FFFF, rd, ill, dwe);
      csr_go(1'b0, 12'h7b1, 1'b1, 32'hFFFF_FFFF, rd, ill, dwe);
      csr_go(1'b1, 12'h7b0, 1'b0, '0, rd, ill, dwe);
      check("R11 dcsr unchanged", rd, dcsr_exp(1'b0, 1'b0, 3'd0));
      csr_go(1'b1, 12'h7b1, 1'b0, '0, rd, ill, dwe);
      check("R11 dpc unchanged", rd, 32'h0);

      // R10 dpc write alignment
      csr_go(1'b1, 12'h7b1, 1'b1, 32'hFFFF_FFFF, rd, ill, dwe);
      csr_go(1'b1, 12'h7b1, 1'b0, '0, rd, ill, dwe);
      check("R10 dpc write", rd, 32'hFFFF_FFFC);

      // R8 / R9 entry with every cause
      for (int c = 1; c <= 4; c++) begin
         @(negedge clk);
         dbg_entry = 1'b1; dbg_entry_cause = 3'(c); dbg_entry_pc = 32'h1000_0003 + 32'(c * 32'h111);
         @(negedge clk);
         dbg_entry = 1'b0;
         csr_go(1'b1, 12'h7b0, 1'b0, '0, rd, ill, dwe);
         check("R8 cause load", rd, dcsr_exp(1'b0, 1'b0, 3'(c)));
         csr_go(1'b1, 12'h7b1, 1'b0, '0, rd, ill, dwe);
         check("R9 dpc load", rd, (32'h1000_0003 + 32'(c * 32'h111)) & 32'hFFFF_FFFC);
      end

      // R9 entry wins over same-cycle writes
      @(negedge clk);
      dbg_mode = 1'b1; csr_en = 1'b1; csr_wen = 1'b1; csr_addr = 12'h7b1; csr_wdata = 32'h0000_0040;
      dbg_entry = 1'b1; dbg_entry_cause = 3'd2; dbg_entry_pc = 32'h8000_0106;
      @(negedge clk);
      csr_en = 1'b0; csr_wen = 1'b0; dbg_entry = 1'b0;
      csr_go(1'b1, 12'h7b1, 1'b0, '0, rd, ill, dwe);
      check("R9 entry beats dpc write", rd, 32'h8000_0104);
      @(negedge clk);
      csr_en = 1'b1; csr_wen = 1'b1; csr_addr = 12'h7b0; csr_wdata = 32'hFFFF_FFFF;
      dbg_entry = 1'b1; dbg_entry_cause = 3'd3; dbg_entry_pc = 32'h0;
      @(negedge clk);
      csr_en = 1'b0; csr_wen = 1'b0; dbg_entry = 1'b0;
      csr_go(1'b1, 12'h7b0, 1'b0, '0, rd, ill, dwe);
      check("R9 entry beats dcsr write", rd, dcsr_exp(1'b0, 1'b0, 3'd3));

      // R7 cause ignores CSR write
      csr_go(1'b1, 12'h7b0, 1'b1, 32'h0000_0004, rd, ill, dwe);
      csr_go(1'b1, 12'h7b0, 1'b0, '0, rd, ill, dwe);
      check("R7 cause kept, step set", rd, dcsr_exp(1'b0, 1'b1, 3'd3));

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule